// File: doc/BRIEF.md
# Dual-Pin Edge Timestamp Capture

This block records when signal transitions arrive on two input pins. A shared 12-bit counter advances once per 1 MHz tick-enable pulse. Each pin has two 8-bit capture slots, one for rising transitions and one for falling transitions. When a transition of the matching polarity is seen, an 8-bit window of the counter is copied into that slot. A 3-bit prescale field picks the window, so software trades resolution against range.

A single configuration register holds four interrupt enables, the prescale field and a hold mode. In hold mode a slot keeps its first timestamp until software reads it. Each pin drives its own interrupt request, which pulses for one clock whenever an enabled slot of that pin takes a capture. Both pins pass through a two-flop synchroniser before edge detection.

Top module: `edge_capture_timer`

## Requirements
- R1: The timebase is a 12-bit counter that resets to 0. It increments by one on every clock with `tick_1mhz` high, holds otherwise, and wraps from 4095 to 0.
- R2: A rising edge on `pin_a` loads the selected counter window into the slot at 0x40, and a falling edge loads the slot at 0x41. For `pin_b`, rising loads 0x42 and falling loads 0x43.
- R3: Prescale value n in the range 0 to 4 selects counter bits [n+7:n]. Values 5, 6 and 7 select bits [11:4], the same as 4.
- R4: The configuration register sits at 0x44. It is readable and writable and resets to 0.
  - Bit 0 enables the interrupt for pin A rising.
  - Bit 1 enables the interrupt for pin A falling.
  - Bit 2 enables the interrupt for pin B rising.
  - Bit 3 enables the interrupt for pin B falling.
  - Bits 6:4 hold the prescale field.
  - Bit 7 selects hold mode.
- R5: The four capture slots reset to 0 and are read-only: a bus write to 0x40 to 0x43 changes nothing. Reads of unmapped addresses return 0.
- R6: With hold mode set, a slot that has captured ignores further edges until a read strobe addresses it. The first edge after that read captures again.
- R7: With hold mode clear, every matching edge overwrites the slot.
- R8: `irq_a` pulses high for exactly one clock when a pin A slot captures and that slot's enable bit is set. `irq_b` does the same for pin B. With the enable bit clear, no pulse appears.
- R9: A pin change is seen through a two-flop synchroniser. The slot updates on the third rising clock edge after the pin changes, and one transition causes exactly one capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1mhz | input | 1 | Timebase advance enable |
| pin_a | input | 1 | Asynchronous input of channel A |
| pin_b | input | 1 | Asynchronous input of channel B |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (releases a held slot) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| irq_a | output | 1 | Channel A interrupt pulse |
| irq_b | output | 1 | Channel B interrupt pulse |

## Verification
The bound checker checks the following on every cycle:
- the counter step and hold behaviour;
- that every accepted capture lands the previous cycle's counter window in its slot;
- that locked slots stay stable in hold mode;
- that bus writes never alter a slot;
- that rising and falling detections are mutually exclusive;
- that an interrupt only follows an enabled capture.

The bench scenarios alone can show the following:
- the absolute timestamp values for each prescale setting, including the clamped codes and counter wrap;
- the exact three-clock synchroniser latency;
- that a read releases a held slot;
- that one transition yields exactly one interrupt pulse.

// File: rtl/ect_pkg.sv
package ect_pkg;
  localparam int CNT_W     = 12;
  localparam int CAP_W     = 8;
  localparam int PS_W      = 3;
  localparam int NUM_SLOTS = 4;
  localparam int MAX_SHIFT = CNT_W - CAP_W;

  typedef struct packed {
    logic             hold;
    logic [PS_W-1:0]  ps;
    logic [NUM_SLOTS-1:0] irq_en;
  } cfg_t;

  // Window of the counter chosen by the prescale code, clamped at the top.
  function automatic logic [CAP_W-1:0] pick_slice(input logic [CNT_W-1:0] cnt,
                                                   input logic [PS_W-1:0] ps);
    int sh;
    sh = (int'(ps) > MAX_SHIFT) ? MAX_SHIFT : int'(ps);
    return CAP_W'(cnt >> sh);
  endfunction
endpackage

// File: rtl/ect_timebase.sv
module ect_timebase #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_o <= '0;
    else if (tick_i) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/ect_pin_sync.sv
module ect_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o =  sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/ect_capture_slot.sv
module ect_capture_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         edge_i,
  input  logic         hold_i,
  input  logic         rd_clr_i,
  input  logic [W-1:0] slice_i,
  output logic [W-1:0] data_o,
  output logic         take_o,
  output logic         locked_o
);
  assign take_o = edge_i & ~(hold_i & locked_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o   <= '0;
      locked_o <= 1'b0;
    end else begin
      if (take_o) data_o <= slice_i;
      locked_o <= hold_i & (take_o | (locked_o & ~rd_clr_i));
    end
  end
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ect_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  BASE_ADDR = 8'h40,
  parameter int          SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1mhz,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_a,
  output logic              irq_b
);
  localparam logic [ADDR_W-1:0] SLOT_BASE = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] CFG_ADDR  = SLOT_BASE + ADDR_W'(NUM_SLOTS);

  cfg_t                  cfg_q;
  logic [CNT_W-1:0]      count;
  logic [CAP_W-1:0]      slice;
  logic                  rise_a, fall_a, rise_b, fall_b;
  logic [NUM_SLOTS-1:0]  edge_vec, take_vec, lock_vec, rd_hit, irq_hit;
  logic [NUM_SLOTS-1:0][CAP_W-1:0] slot_data;

  ect_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_1mhz), .count_o(count));

  ect_pin_sync #(.STAGES(SYNC_STG)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_a), .rise_o(rise_a), .fall_o(fall_a));
  ect_pin_sync #(.STAGES(SYNC_STG)) u_sync_b (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_b), .rise_o(rise_b), .fall_o(fall_b));

  assign slice    = pick_slice(count, cfg_q.ps);
  assign edge_vec = {fall_b, rise_b, fall_a, rise_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cfg_q <= '0;
    else if (bus_wr && bus_addr == CFG_ADDR) cfg_q <= cfg_t'(bus_wdata[7:0]);
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign rd_hit[i] = bus_rd && (bus_addr == SLOT_BASE + ADDR_W'(i));
    ect_capture_slot #(.W(CAP_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .edge_i(edge_vec[i]), .hold_i(cfg_q.hold),
      .rd_clr_i(rd_hit[i]), .slice_i(slice), .data_o(slot_data[i]),
      .take_o(take_vec[i]), .locked_o(lock_vec[i]));
  end

  assign irq_hit = take_vec & cfg_q.irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_a <= 1'b0;
      irq_b <= 1'b0;
    end else begin
      irq_a <= |irq_hit[1:0];
      irq_b <= |irq_hit[3:2];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (bus_addr == SLOT_BASE + ADDR_W'(i)) bus_rdata = DATA_W'(slot_data[i]);
    if (bus_addr == CFG_ADDR) bus_rdata = DATA_W'(cfg_q);
  end
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
  parameter int         CNT_W     = 12,
  parameter int         CAP_W     = 8,
  parameter int         NSLOT     = 4,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] BASE_ADDR = 8'h40
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tick,
  input logic [CNT_W-1:0]             count,
  input logic [CAP_W-1:0]             slice,
  input logic                         rise_a,
  input logic                         fall_a,
  input logic                         rise_b,
  input logic                         fall_b,
  input logic [NSLOT-1:0]             take,
  input logic [NSLOT-1:0]             locked,
  input logic [NSLOT-1:0]             rd_hit,
  input logic [NSLOT-1:0][CAP_W-1:0]  data,
  input logic [7:0]                   cfg,
  input logic                         bus_wr,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic                         irq_a,
  input logic                         irq_b
);
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == CNT_W'($past(count) + 1'b1));
  // R1
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  // R9
  edge_excl_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_a, fall_a}));
  // R9
  edge_excl_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_b, fall_b}));
  // R8
  irq_a_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> $past((take[0] && cfg[0]) || (take[1] && cfg[1])));
  // R8
  irq_b_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b |-> $past((take[2] && cfg[2]) || (take[3] && cfg[3])));

  for (genvar i = 0; i < NSLOT; i++) begin : g_chk
    // R2
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take[i] |=> data[i] == $past(slice));
    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[7] && locked[i] && !rd_hit[i]) |=> $stable(data[i]));
    // R5
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(BASE_ADDR) + ADDR_W'(i) && !take[i]) |=> $stable(data[i]));
  end
endmodule

bind edge_capture_timer ect_checker #(
  .CNT_W(ect_pkg::CNT_W), .CAP_W(ect_pkg::CAP_W), .NSLOT(ect_pkg::NUM_SLOTS),
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_ect_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_1mhz), .count(count), .slice(slice),
  .rise_a(rise_a), .fall_a(fall_a), .rise_b(rise_b), .fall_b(fall_b),
  .take(take_vec), .locked(lock_vec), .rd_hit(rd_hit), .data(slot_data),
  .cfg(cfg_q), .bus_wr(bus_wr), .bus_addr(bus_addr), .irq_a(irq_a), .irq_b(irq_b));

// File: tb/test_edge_capture_timer.sv
module test_edge_capture_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       pa = 1'b0, pb = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic       irq_a, irq_b;

  int checks = 0, errors = 0;
  int model_cnt = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  edge_capture_timer i_edge_capture_timer (
    .clk(clk), .rst_n(rst_n), .tick_1mhz(tick), .pin_a(pa), .pin_b(pb),
    .bus_addr(addr), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_a(irq_a), .irq_b(irq_b));

  // vector: {channel(1), polarity 1=rise(1), prescale(3), ticks(12)}
  localparam int NV = 8;
  localparam logic [NV-1:0][16:0] VEC = '{
    {1'b0, 1'b1, 3'd0, 12'd37},
    {1'b0, 1'b0, 3'd1, 12'd300},
    {1'b1, 1'b1, 3'd2, 12'd1000},
    {1'b1, 1'b0, 3'd3, 12'd123},
    {1'b0, 1'b1, 3'd4, 12'd2500},
    {1'b0, 1'b0, 3'd5, 12'd77},
    {1'b1, 1'b1, 3'd7, 12'd3000},
    {1'b1, 1'b0, 3'd6, 12'd900}
  };

  function automatic logic [7:0] exp_win(input int c, input int ps);
    int div;
    div = 1 << ((ps >= 4) ? 4 : ps);
    return 8'((c / div) % 256);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic advance(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    model_cnt = (model_cnt + n) % 4096;
  endtask

  task automatic drive_pin(input logic ch, input logic v, output int pulses);
    pulses = 0;
    @(negedge clk);
    if (ch) pb = v; else pa = v;
    repeat (6) begin
      @(negedge clk);
      if (ch ? irq_b : irq_a) pulses++;
    end
  endtask

  task automatic make_edge(input logic ch, input logic pol, output int pulses);
    int dummy;
    drive_pin(ch, !pol, dummy);
    drive_pin(ch, pol, pulses);
  endtask

  initial begin
    logic [7:0] d, c1;
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4 R5: reset state
    for (int a = 8'h40; a <= 8'h44; a++) begin
      peek(8'(a), d);
      check("R5 reset read", d, 0);
    end
    check("R8 reset irq", {irq_a, irq_b}, 0);

    // R9: three-edge latency, R8: disabled enables give no pulse
    advance(10);
    @(negedge clk); pa = 1'b1; addr = 8'h40;
    p = 0;
    @(negedge clk); @(negedge clk);
    check("R9 not yet captured", rdata, 0);
    @(negedge clk);
    check("R9 captured on third edge", rdata, 10);
    repeat (4) begin @(negedge clk); if (irq_a) p++; end
    check("R8 disabled no pulse", p, 0);

    // R4: config read/write
    bus_write(8'h44, 8'hA5);
    peek(8'h44, d);
    check("R4 cfg readback", d, 8'hA5);

    // R5: writes ignored, unmapped reads zero
    bus_write(8'h40, 8'hFF);
    peek(8'h40, d);
    check("R5 slot write ignored", d, 10);
    peek(8'h50, d);
    check("R5 unmapped read", d, 0);

    // R2 R3 R8: vector table
    for (int i = 0; i < NV; i++) begin
      logic ch, pol;
      int ps, tk;
      logic [7:0] sa;
      {ch, pol} = VEC[i][16:15];
      ps = int'(VEC[i][14:12]);
      tk = int'(VEC[i][11:0]);
      bus_write(8'h44, {1'b0, 3'(ps), 4'hF});
      advance(tk);
      make_edge(ch, pol, p);
      sa = 8'h40 + {6'd0, ch, 1'b0} + (pol ? 8'd0 : 8'd1);
      peek(sa, d);
      check($sformatf("R2 R3 vec%0d window", i), d, exp_win(model_cnt, ps));
      check($sformatf("R8 vec%0d single pulse", i), p, 1);
    end

    // R1: wrap past 4095
    bus_write(8'h44, 8'h00);
    advance(4096 + 6);
    make_edge(1'b0, 1'b0, p);
    peek(8'h41, d);
    check("R1 wrap", d, exp_win(model_cnt, 0));

    // R7: overwrite without hold
    advance(20);
    make_edge(1'b1, 1'b1, p);
    advance(5);
    make_edge(1'b1, 1'b1, p);
    peek(8'h42, d);
    check("R7 overwrite", d, exp_win(model_cnt, 0));

    // R6: hold mode
    bus_write(8'h44, 8'h80);
    advance(5);
    make_edge(1'b0, 1'b1, p);
    c1 = exp_win(model_cnt, 0);
    advance(9);
    make_edge(1'b0, 1'b1, p);
    peek(8'h40, d);
    check("R6 held value kept", d, c1);
    bus_read(8'h40, d);
    check("R6 read returns held", d, c1);
    advance(3);
    make_edge(1'b0, 1'b1, p);
    peek(8'h40, d);
    check("R6 capture after read", d, exp_win(model_cnt, 0));

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule